// File: doc/BRIEF.md
# Per-Circuit Cell Reassembly Buffer

This block takes in a multiplexed stream of fixed-size network cells, each carrying a circuit number, an end-of-frame marker and a 48-byte payload. Every accepted payload goes into one slot of a shared pool. The slots that belong to one circuit are chained into a linked list, so cells from interleaved circuits stay separate and in arrival order. A frame is counted for its circuit once the cell that ends it has been stored.

The host starts a drain by giving a circuit, a destination byte address and a byte limit. The block then writes that circuit's stored payload bytes, one byte per handshake, to consecutive addresses through a memory-write master port. The drain stops at the end of the frame or when the limit is reached, whichever comes first. Each slot is returned to the pool as soon as its last byte has gone out. The block raises no interrupt. The host polls a busy flag, a done flag, the byte count of the last drain and a per-circuit count of waiting frames.

Back-pressure rules: the cell input never stalls. `cell_ready` is high whenever reset is low, and a cell offered while no slot is free is dropped. The write port holds its address and data while `wr_ready` is low.

Top module: `cell_reasm`

## Requirements
- R1: Out of reset `cell_ready` is high. A cell is taken on every cycle in which `cell_valid` is high, and it is stored whenever a free slot exists.
- R2: Cells are chained per circuit. A drain of circuit v writes only bytes from cells that arrived on v, in their arrival order, even when other circuits' cells were interleaved with them.
- R3: `stat_frames` gives the number of complete frames waiting on circuit `stat_vc`. It rises by one on the clock edge that stores a cell with `cell_eof`=1, and it does not rise for any other cell. It falls by one when the drain frees a slot that holds an end-of-frame cell.
- R4: A command is accepted when `cmd_valid` is high and `busy` is low. Payload byte i of a cell occupies `cell_data[8i+7:8i]`. Bytes are written one per `wr_valid`&&`wr_ready` beat. The n-th byte of the drain (counting from 0) goes to address `cmd_addr`+n.
- R5: A drain stops after the last byte of the end-of-frame cell, or after `cmd_size` bytes, whichever comes first. `xfer_bytes` then holds the number of bytes written. A frame cut short by the limit keeps its remaining cells queued, and the rest of the cell in which the drain stopped is discarded.
- R6: A command for a circuit with zero waiting frames, or with `cmd_size`=0, writes nothing. `done` rises on the next cycle and `xfer_bytes`=0.
- R7: At most one drain is in progress. `cmd_valid` has no effect while `busy` is high. An accepted command clears `done`, and `done` is set on the cycle after the final byte beat.
- R8: Each slot is returned to the pool when its last byte has been written, or when the drain stops inside it. After every stored cell has been drained, all NUM_SLOTS slots can be filled again.
- R9: A cell offered with no free slot is dropped, leaves every frame count unchanged, and sets the sticky `overflow` flag, which only reset clears. Cell input and drains keep working afterwards.
- R10: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold their values.
- R11: After reset, `busy`, `done`, `overflow` and `xfer_bytes` are 0, and every circuit reports zero frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cell_valid | input | 1 | A cell is offered |
| cell_ready | output | 1 | Cell input accepts (high out of reset) |
| cell_vc | input | VW | Circuit number of the cell |
| cell_eof | input | 1 | The cell ends its frame |
| cell_data | input | 384 | Payload, byte i in bits 8i+7:8i |
| cmd_valid | input | 1 | Drain command strobe |
| cmd_vc | input | VW | Circuit to drain |
| cmd_addr | input | ADDR_W | First destination byte address |
| cmd_size | input | SIZE_W | Byte limit of the drain |
| busy | output | 1 | A drain is in progress |
| done | output | 1 | The last accepted drain has finished |
| xfer_bytes | output | SIZE_W | Bytes written by the last finished drain |
| stat_vc | input | VW | Circuit selected for frame status |
| stat_frames | output | CW | Complete frames waiting on stat_vc |
| overflow | output | 1 | Sticky: a cell was dropped for lack of a slot |
| wr_valid | output | 1 | A write byte is offered |
| wr_ready | input | 1 | The memory takes the byte |
| wr_addr | output | ADDR_W | Destination byte address |
| wr_data | output | 8 | Data byte |

## Verification
The assertions take for granted that `cell_vc`, `cmd_vc` and `stat_vc` stay below NUM_VC. They also assume that `wr_ready` is driven to a known level on every cycle of a drain and that the write side never accepts a byte that was not offered. The stimulus uses only circuits 0 to 3 with the default four circuits. It drives `wr_ready` and every command at the falling edge, either constantly high or pseudo-randomly low about one cycle in four. It fills the pool exactly to NUM_SLOTS before offering the one cell that must be dropped. Frame limits are swept across 0, 1 and the sizes around a cell boundary.

// File: rtl/cell_reasm_pkg.sv
package cell_reasm_pkg;
  localparam int CELL_BYTES = 48;
  localparam int CELL_W     = CELL_BYTES * 8;
  localparam int BIDX_W     = $clog2(CELL_BYTES);
  typedef enum logic {DR_IDLE, DR_MOVE} drain_state_t;
endpackage

// File: rtl/cr_free_list.sv
module cr_free_list #(
  parameter int NUM_SLOTS = 8
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           pop,
  output logic                           pop_ok,
  output logic [$clog2(NUM_SLOTS)-1:0]   pop_idx,
  input  logic                           push,
  input  logic [$clog2(NUM_SLOTS)-1:0]   push_idx,
  output logic [$clog2(NUM_SLOTS+1)-1:0] free_cnt
);
  localparam int IW = $clog2(NUM_SLOTS);
  localparam int CW = $clog2(NUM_SLOTS + 1);

  logic [IW-1:0] ring [NUM_SLOTS];
  logic [IW-1:0] rd_ptr, wr_ptr;
  logic          do_pop;

  function automatic logic [IW-1:0] step(input logic [IW-1:0] p);
    return (p == IW'(NUM_SLOTS - 1)) ? '0 : p + IW'(1);
  endfunction

  assign pop_ok  = (free_cnt != '0);
  assign pop_idx = ring[rd_ptr];
  assign do_pop  = pop && pop_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) ring[i] <= IW'(i);
      rd_ptr   <= '0;
      wr_ptr   <= '0;
      free_cnt <= CW'(NUM_SLOTS);
    end else begin
      if (do_pop) rd_ptr <= step(rd_ptr);
      if (push) begin
        ring[wr_ptr] <= push_idx;
        wr_ptr       <= step(wr_ptr);
      end
      free_cnt <= free_cnt + CW'(push) - CW'(do_pop);
    end
  end

  // R8: a slot is never handed back while the pool already holds every slot
  assert_no_double_free_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> (free_cnt < CW'(NUM_SLOTS)));
  assert_free_bound_R8: assert property (@(posedge clk) disable iff (rst)
    free_cnt <= CW'(NUM_SLOTS));
endmodule

// File: rtl/cr_slot_store.sv
module cr_slot_store
  import cell_reasm_pkg::*;
#(
  parameter int NUM_SLOTS = 8
) (
  input  logic                         clk,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_SLOTS)-1:0] wr_idx,
  input  logic [CELL_W-1:0]            wr_data,
  input  logic                         wr_eof,
  input  logic                         link_en,
  input  logic [$clog2(NUM_SLOTS)-1:0] link_from,
  input  logic [$clog2(NUM_SLOTS)-1:0] link_to,
  input  logic [$clog2(NUM_SLOTS)-1:0] rd_idx,
  output logic [CELL_W-1:0]            rd_data,
  output logic                         rd_eof,
  output logic [$clog2(NUM_SLOTS)-1:0] rd_next
);
  localparam int IW = $clog2(NUM_SLOTS);

  logic [CELL_W-1:0] payload [NUM_SLOTS];
  logic              eof_bit [NUM_SLOTS];
  logic [IW-1:0]     next_of [NUM_SLOTS];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      payload[wr_idx] <= wr_data;
      eof_bit[wr_idx] <= wr_eof;
    end
    if (link_en) next_of[link_from] <= link_to;
  end

  assign rd_data = payload[rd_idx];
  assign rd_eof  = eof_bit[rd_idx];
  assign rd_next = next_of[rd_idx];
endmodule

// File: rtl/cr_chain_table.sv
module cr_chain_table #(
  parameter int NUM_VC    = 4,
  parameter int NUM_SLOTS = 8,
  parameter int VW        = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           arrive,
  input  logic [VW-1:0]                  arr_vc,
  input  logic [$clog2(NUM_SLOTS)-1:0]   arr_slot,
  input  logic                           arr_eof,
  input  logic                           rel,
  input  logic [VW-1:0]                  rel_vc,
  input  logic                           rel_eof,
  input  logic [$clog2(NUM_SLOTS)-1:0]   rel_next,
  output logic                           link_en,
  output logic [$clog2(NUM_SLOTS)-1:0]   link_from,
  input  logic [VW-1:0]                  q_vc,
  output logic [$clog2(NUM_SLOTS)-1:0]   q_head,
  output logic [$clog2(NUM_SLOTS+1)-1:0] q_frames,
  input  logic [VW-1:0]                  s_vc,
  output logic [$clog2(NUM_SLOTS+1)-1:0] s_frames
);
  localparam int IW = $clog2(NUM_SLOTS);
  localparam int CW = $clog2(NUM_SLOTS + 1);

  logic [IW-1:0] head   [NUM_VC];
  logic [IW-1:0] tail   [NUM_VC];
  logic [CW-1:0] cells  [NUM_VC];
  logic [CW-1:0] frames [NUM_VC];
  logic [NUM_VC-1:0] arr_hit, rel_hit, empties;

  always_comb begin
    for (int v = 0; v < NUM_VC; v++) begin
      arr_hit[v] = arrive && (arr_vc == VW'(v));
      rel_hit[v] = rel && (rel_vc == VW'(v));
      // chain holds nothing once this cycle's release is applied
      empties[v] = (cells[v] == '0) || (rel_hit[v] && cells[v] == CW'(1));
    end
  end

  assign link_en   = arrive && !empties[arr_vc];
  assign link_from = tail[arr_vc];
  assign q_head    = head[q_vc];
  assign q_frames  = frames[q_vc];
  assign s_frames  = frames[s_vc];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int v = 0; v < NUM_VC; v++) begin
        head[v]   <= '0;
        tail[v]   <= '0;
        cells[v]  <= '0;
        frames[v] <= '0;
      end
    end else begin
      for (int v = 0; v < NUM_VC; v++) begin
        if (arr_hit[v]) tail[v] <= arr_slot;
        if (arr_hit[v] && empties[v]) head[v] <= arr_slot;
        else if (rel_hit[v])          head[v] <= rel_next;
        cells[v]  <= cells[v] + CW'(arr_hit[v]) - CW'(rel_hit[v]);
        frames[v] <= frames[v] + CW'(arr_hit[v] && arr_eof)
                               - CW'(rel_hit[v] && rel_eof);
      end
    end
  end

  for (genvar g = 0; g < NUM_VC; g++) begin : g_chk
    // R3: no frame is counted unless an end-of-frame cell was stored on this circuit
    assert_frames_need_eof_R3: assert property (@(posedge clk) disable iff (rst)
      !(arr_hit[g] && arr_eof) |=> (frames[g] <= $past(frames[g])));
    // R2: every counted frame owns at least one slot of its own chain
    assert_frames_within_chain_R2: assert property (@(posedge clk) disable iff (rst)
      frames[g] <= cells[g]);
  end
endmodule

// File: rtl/cr_drain_seq.sv
module cr_drain_seq
  import cell_reasm_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int VW        = 2,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 17
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cmd_valid,
  input  logic [VW-1:0]                  cmd_vc,
  input  logic [ADDR_W-1:0]              cmd_addr,
  input  logic [SIZE_W-1:0]              cmd_size,
  output logic [VW-1:0]                  q_vc,
  input  logic [$clog2(NUM_SLOTS)-1:0]   q_head,
  input  logic [$clog2(NUM_SLOTS+1)-1:0] q_frames,
  output logic [$clog2(NUM_SLOTS)-1:0]   rd_idx,
  input  logic [CELL_W-1:0]              rd_data,
  input  logic                           rd_eof,
  output logic                           rel,
  output logic [VW-1:0]                  rel_vc,
  output logic                           rel_eof,
  output logic                           wr_valid,
  input  logic                           wr_ready,
  output logic [ADDR_W-1:0]              wr_addr,
  output logic [7:0]                     wr_data,
  input  logic [$clog2(NUM_SLOTS)-1:0]   rd_next,
  output logic                           busy,
  output logic                           done,
  output logic [SIZE_W-1:0]              xfer_bytes
);
  localparam int IW = $clog2(NUM_SLOTS);

  drain_state_t       state;
  logic [VW-1:0]      vc_r;
  logic [ADDR_W-1:0]  base;
  logic [SIZE_W-1:0]  size_r, bcnt;
  logic [BIDX_W-1:0]  bidx;
  logic [IW-1:0]      cur;
  logic               beat, hit_size, cell_end, finish;

  assign busy     = (state == DR_MOVE);
  assign q_vc     = busy ? vc_r : cmd_vc;
  assign rd_idx   = cur;
  assign wr_valid = busy;
  assign wr_addr  = base + ADDR_W'(bcnt);
  assign wr_data  = rd_data[bidx*8 +: 8];

  assign beat     = wr_valid && wr_ready;
  assign hit_size = (bcnt + SIZE_W'(1)) == size_r;
  assign cell_end = beat && (hit_size || bidx == BIDX_W'(CELL_BYTES - 1));
  assign finish   = cell_end && (rd_eof || hit_size);

  assign rel     = cell_end;
  assign rel_vc  = vc_r;
  assign rel_eof = rd_eof;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= DR_IDLE;
      vc_r       <= '0;
      base       <= '0;
      size_r     <= '0;
      bcnt       <= '0;
      bidx       <= '0;
      cur        <= '0;
      done       <= 1'b0;
      xfer_bytes <= '0;
    end else if (state == DR_IDLE) begin
      if (cmd_valid) begin
        vc_r   <= cmd_vc;
        base   <= cmd_addr;
        size_r <= cmd_size;
        bcnt   <= '0;
        bidx   <= '0;
        cur    <= q_head;
        if (q_frames == '0 || cmd_size == '0) begin
          done       <= 1'b1;
          xfer_bytes <= '0;
        end else begin
          done  <= 1'b0;
          state <= DR_MOVE;
        end
      end
    end else if (beat) begin
      bcnt <= bcnt + SIZE_W'(1);
      bidx <= cell_end ? '0 : bidx + BIDX_W'(1);
      if (cell_end) cur <= rd_next;
      if (finish) begin
        state      <= DR_IDLE;
        done       <= 1'b1;
        xfer_bytes <= bcnt + SIZE_W'(1);
      end
    end
  end

  assert_wr_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
  assert_size_bound_R5: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < size_r));
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: rtl/cell_reasm.sv
module cell_reasm
  import cell_reasm_pkg::*;
#(
  parameter int NUM_VC    = 4,
  parameter int NUM_SLOTS = 8,
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 17,
  localparam int VW = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int CW = $clog2(NUM_SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cell_valid,
  output logic              cell_ready,
  input  logic [VW-1:0]     cell_vc,
  input  logic              cell_eof,
  input  logic [CELL_W-1:0] cell_data,
  input  logic              cmd_valid,
  input  logic [VW-1:0]     cmd_vc,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [SIZE_W-1:0] cmd_size,
  output logic              busy,
  output logic              done,
  output logic [SIZE_W-1:0] xfer_bytes,
  input  logic [VW-1:0]     stat_vc,
  output logic [CW-1:0]     stat_frames,
  output logic              overflow,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int IW = $clog2(NUM_SLOTS);

  logic          take, pop_ok, arrive, link_en, rel, rel_eof, rd_eof;
  logic [IW-1:0] pop_idx, link_from, q_head, rd_idx, rd_next;
  logic [CW-1:0] free_cnt, q_frames;
  logic [VW-1:0] q_vc, rel_vc;
  logic [CELL_W-1:0] rd_data;

  assign cell_ready = !rst;
  assign take       = cell_valid && cell_ready;
  assign arrive     = take && pop_ok;

  always_ff @(posedge clk) begin
    if (rst) overflow <= 1'b0;
    else if (take && !pop_ok) overflow <= 1'b1;
  end

  cr_free_list #(.NUM_SLOTS(NUM_SLOTS)) u_free (
    .clk(clk), .rst(rst), .pop(take), .pop_ok(pop_ok), .pop_idx(pop_idx),
    .push(rel), .push_idx(rd_idx), .free_cnt(free_cnt));

  cr_slot_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .wr_en(arrive), .wr_idx(pop_idx), .wr_data(cell_data),
    .wr_eof(cell_eof), .link_en(link_en), .link_from(link_from),
    .link_to(pop_idx), .rd_idx(rd_idx), .rd_data(rd_data), .rd_eof(rd_eof),
    .rd_next(rd_next));

  cr_chain_table #(.NUM_VC(NUM_VC), .NUM_SLOTS(NUM_SLOTS), .VW(VW)) u_chain (
    .clk(clk), .rst(rst), .arrive(arrive), .arr_vc(cell_vc), .arr_slot(pop_idx),
    .arr_eof(cell_eof), .rel(rel), .rel_vc(rel_vc), .rel_eof(rel_eof),
    .rel_next(rd_next), .link_en(link_en), .link_from(link_from),
    .q_vc(q_vc), .q_head(q_head), .q_frames(q_frames),
    .s_vc(stat_vc), .s_frames(stat_frames));

  cr_drain_seq #(.NUM_SLOTS(NUM_SLOTS), .VW(VW), .ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_drain (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_vc(cmd_vc),
    .cmd_addr(cmd_addr), .cmd_size(cmd_size), .q_vc(q_vc), .q_head(q_head),
    .q_frames(q_frames), .rd_idx(rd_idx), .rd_data(rd_data), .rd_eof(rd_eof),
    .rel(rel), .rel_vc(rel_vc), .rel_eof(rel_eof), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_next(rd_next), .busy(busy), .done(done), .xfer_bytes(xfer_bytes));

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R9: a dropped cell means the pool really was empty
  assert_drop_only_when_full_R9: assert property (@(posedge clk) disable iff (rst)
    (take && !pop_ok) |-> (free_cnt == '0));
endmodule

// File: tb/cell_reasm_test.sv
module cell_reasm_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVC = 4;
  localparam int NSL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cell_valid = 1'b0, cell_eof = 1'b0, cmd_valid = 1'b0, wr_ready = 1'b1;
  logic [1:0] cell_vc = '0, cmd_vc = '0, stat_vc = '0;
  logic [383:0] cell_data = '0;
  logic [31:0] cmd_addr = '0;
  logic [16:0] cmd_size = '0;
  logic cell_ready, busy, done, overflow, wr_valid;
  logic [16:0] xfer_bytes;
  logic [3:0] stat_frames;
  logic [31:0] wr_addr;
  logic [7:0] wr_data;

  cell_reasm uut (
    .clk(clk), .rst(rst), .cell_valid(cell_valid), .cell_ready(cell_ready),
    .cell_vc(cell_vc), .cell_eof(cell_eof), .cell_data(cell_data),
    .cmd_valid(cmd_valid), .cmd_vc(cmd_vc), .cmd_addr(cmd_addr),
    .cmd_size(cmd_size), .busy(busy), .done(done), .xfer_bytes(xfer_bytes),
    .stat_vc(stat_vc), .stat_frames(stat_frames), .overflow(overflow),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
    .wr_data(wr_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, failures = 0, cycles = 0;
  int m_tag [NVC][64];
  bit m_eof [NVC][64];
  int m_h [NVC], m_t [NVC], m_frames [NVC];
  int m_free = NSL, next_tag = 1;
  bit m_ovf = 0, stall_en = 0;
  logic [31:0] cap_addr [512];
  logic [7:0]  cap_data [512];
  int ncap = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // write-side model: pick ready, record the byte that the next edge takes
  always @(negedge clk) begin
    wr_ready = stall_en ? (($urandom % 4) != 0) : 1'b1;
    if (wr_valid && wr_ready && ncap < 512) begin
      cap_addr[ncap] = wr_addr;
      cap_data[ncap] = wr_data;
      ncap++;
    end
  end

  function automatic logic [7:0] pbyte(input int tag, input int j);
    return 8'((tag * 5 + j + 1) & 255);
  endfunction

  task automatic send_cell(input int vc, input bit eof);
    @(negedge clk);
    cell_valid = 1'b1;
    cell_vc = 2'(vc);
    cell_eof = eof;
    for (int j = 0; j < 48; j++) cell_data[j*8 +: 8] = pbyte(next_tag, j);
    @(negedge clk);
    cell_valid = 1'b0;
    if (m_free > 0) begin
      m_tag[vc][m_t[vc] % 64] = next_tag;
      m_eof[vc][m_t[vc] % 64] = eof;
      m_t[vc]++;
      m_free--;
      if (eof) m_frames[vc]++;
    end else m_ovf = 1;
    next_tag++;
  endtask

  task automatic frames_of(input int vc, output int f);
    stat_vc = 2'(vc);
    #1;
    f = int'(stat_frames);
  endtask

  task automatic drain(input int vc, input int addr, input int size, input string req,
                       input bit inject, input int other_vc);
    int exp_n, bad, k, f, fo;
    bit stop;
    frames_of(other_vc, fo);
    ncap = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_vc = 2'(vc);
    cmd_addr = 32'(addr);
    cmd_size = 17'(size);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (inject) begin
      @(negedge clk);
      check(busy === 1'b1, "R7 busy during drain", busy, 1);
      cmd_valid = 1'b1;
      cmd_vc = 2'(other_vc);
      cmd_size = 17'd65536;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    k = 0;
    while (done !== 1'b1 && k < 5000) begin
      @(negedge clk);
      k++;
    end
    check(done === 1'b1 && busy === 1'b0, {req, " done"}, done, 1);
    // expected bytes from the model
    exp_n = 0;
    bad = 0;
    stop = (m_frames[vc] == 0) || (size == 0);
    while (!stop) begin
      int tag;
      bit eof;
      tag = m_tag[vc][m_h[vc] % 64];
      eof = m_eof[vc][m_h[vc] % 64];
      for (int j = 0; j < 48 && exp_n < size; j++) begin
        if (exp_n >= ncap || cap_data[exp_n] !== pbyte(tag, j) ||
            cap_addr[exp_n] !== 32'(addr + exp_n)) bad++;
        exp_n++;
      end
      m_h[vc]++;
      m_free++;
      if (eof) m_frames[vc]--;
      stop = eof || (exp_n == size);
    end
    check(int'(xfer_bytes) == exp_n, {req, " byte count"}, xfer_bytes, exp_n);
    check(ncap == exp_n && bad == 0, {req, " bytes and addresses"}, ncap + bad, exp_n);
    frames_of(vc, f);
    check(f == m_frames[vc], "R3 frames after drain", f, m_frames[vc]);
    if (inject) begin
      frames_of(other_vc, f);
      check(f == fo, "R7 command while busy ignored", f, fo);
    end
  endtask

  initial begin
    int f;
    for (int v = 0; v < NVC; v++) begin
      m_h[v] = 0; m_t[v] = 0; m_frames[v] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(busy === 1'b0 && done === 1'b0, "R11 busy/done", {busy, done}, 0);
    check(overflow === 1'b0 && xfer_bytes === '0, "R11 overflow/bytes", overflow, 0);
    for (int v = 0; v < NVC; v++) begin
      frames_of(v, f);
      check(f == 0, "R11 frames", f, 0);
    end
    check(cell_ready === 1'b1, "R1 cell_ready", cell_ready, 1);

    // R3 and R2: interleaved circuits, count rises only on end-of-frame
    send_cell(1, 0);
    send_cell(0, 0);
    send_cell(1, 0);
    frames_of(1, f);
    check(f == 0, "R3 no count before eof", f, 0);
    send_cell(2, 1);
    send_cell(1, 1);
    frames_of(1, f);
    check(f == 1, "R3 count on eof", f, 1);
    send_cell(0, 1);
    frames_of(0, f);
    check(f == 1, "R3 count circuit 0", f, 1);
    drain(1, 32'h1000, 65536, "R2 R4 R5 eof stop", 0, 0);
    drain(0, 32'h2000, 65536, "R2 R4 interleaved", 0, 0);
    drain(2, 32'h3000, 65536, "R2 single cell", 0, 0);

    // R6: nothing waiting, and zero size
    drain(3, 32'h4000, 100, "R6 empty circuit", 0, 0);
    send_cell(3, 1);
    drain(3, 32'h4000, 0, "R6 zero size", 0, 0);
    drain(3, 32'h4100, 65536, "R6 remaining frame", 0, 0);

    // R5: size limit inside a frame, then the remainder
    send_cell(0, 0);
    send_cell(0, 0);
    send_cell(0, 1);
    drain(0, 32'h5000, 50, "R5 size limit", 0, 0);
    frames_of(0, f);
    check(f == 1, "R5 frame kept after limit", f, 1);
    drain(0, 32'h5100, 65536, "R5 remainder", 0, 0);

    // R7: second command while busy
    stall_en = 1;
    send_cell(0, 0);
    send_cell(0, 1);
    send_cell(2, 1);
    drain(0, 32'h6000, 65536, "R7 first drain", 1, 2);
    drain(2, 32'h6100, 65536, "R7 later drain", 0, 0);

    // R9 and R8: fill the pool, drop one, drain, refill
    for (int i = 0; i < NSL; i++) send_cell(1, (i % 2) == 1);
    check(overflow === 1'b0, "R9 no overflow at exact fill", overflow, 0);
    send_cell(2, 1);
    check(overflow === 1'b1, "R9 overflow on drop", overflow, 1);
    frames_of(2, f);
    check(f == 0, "R9 dropped cell not counted", f, 0);
    check(cell_ready === 1'b1, "R9 input still ready", cell_ready, 1);
    for (int i = 0; i < NSL / 2; i++) drain(1, 32'h7000 + i * 256, 65536, "R8 R9 drain full pool", 0, 0);
    for (int i = 0; i < NSL; i++) send_cell(3, i == NSL - 1);
    frames_of(3, f);
    check(f == 1, "R8 pool refilled", f, 1);
    drain(3, 32'h8000, 65536, "R8 eight-cell frame", 0, 0);
    check(overflow === 1'b1, "R9 sticky overflow", overflow, 1);

    // sweep: every circuit, 1..3 cells, limits around cell boundaries
    begin
      int sz [6] = '{65536, 1, 47, 48, 49, 100};
      for (int v = 0; v < NVC; v++)
        for (int n = 1; n <= 3; n++)
          for (int s = 0; s < 6; s++) begin
            stall_en = ((v + s) % 2) == 1;
            for (int c = 0; c < n; c++) send_cell(v, c == n - 1);
            drain(v, 32'h10000 + v * 4096 + s, sz[s], "R4 R5 sweep", 0, 0);
            if (m_frames[v] != 0) drain(v, 32'h20000, 65536, "R5 sweep remainder", 0, 0);
          end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule